// File: doc/BRIEF.md
# Per-Channel Analog Watchdog Monitor

The block sits behind a conversion sequencer and watches every finished conversion result. Each result beat carries a channel number (0 to 15) and a 10-bit value. If that channel is enabled for monitoring, the value is checked against a window made of one high and one low threshold, which all channels share. A value outside the window sets a sticky status bit for that channel. The OR of all status bits forms a combined watchdog flag. When the interrupt enable is set, that flag drives the interrupt output.

Results arrive on a valid/ready stream. The block never applies back-pressure: ready is held high, so the sequencer may present a beat on any cycle and the beat counts as taken on the rising edge where valid is high. Software uses a simple byte-wide register port. It writes enables and thresholds, reads status, and clears status bits by writing 1 to them. Reads are combinational from the read address.

Top module: `awd_monitor`

## Requirements
- R1: `res_ready` is 1 in every cycle after reset. Every beat with `res_valid` high at a rising edge is taken as a result. A beat with `res_valid` low changes no state.
- R2: Register map, 8-bit data. Addresses and reset values:
  - Address 0 is the channel 7..0 enables. Address 1 is the channel 15..8 enables. Both reset to 0.
  - Address 2 is the channel 7..0 status. Address 3 is the channel 15..8 status. Both reset to 0.
  - Address 4 is high threshold bits 7..0, and address 5 holds high threshold bits 9..8 in bits 1..0. The high threshold resets to 1023.
  - Address 6 is low threshold bits 7..0, and address 7 holds low threshold bits 9..8 in bits 1..0. The low threshold resets to 0.
  - Address 8 is control. Bit 0 is the interrupt enable (read/write, resets to 0). Bit 1 is the combined flag (read-only).
  - Enables, thresholds and the interrupt enable read back exactly what was written.
- R3: A watchdog event occurs only when the result is strictly greater than the high threshold or strictly less than the low threshold. A value equal to either threshold is not an event.
- R4: A result on channel i whose enable bit is 0 never changes any status bit. The enable for channel i is bit i of address 0 when i < 8, and bit i-8 of address 1 otherwise.
- R5: An event on an enabled channel i sets status bit i at the rising edge that takes the beat. The bit stays set until it is cleared. Status for channel i is bit i of address 2 when i < 8, and bit i-8 of address 3 otherwise.
- R6: Writing a status address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: If an event sets a status bit in the same cycle that a write clears that bit, the bit ends up set.
- R8: The combined flag (address 8, bit 1) is 1 exactly when at least one status bit is 1.
- R9: `irq` equals the combined flag AND the interrupt enable. It follows changes to status or to the enable from the same edge, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Always 1: result beats are never stalled |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 10 | Conversion result |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Watchdog interrupt |

## Verification
The bench puts values exactly on each threshold and one step past it. A design that compares with >= or <= would flag values that lie on the window's edge. It sends out-of-window results on disabled channels, and also sends them with valid low. A design that ignores the enable, or the valid, would set status that should stay clear. The bench clears one bit while another stays set, which catches a clear that wipes the whole register. It also raises an event and clears the same bit in one cycle. A design where the clear wins would lose the event, and the interrupt would drop.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_EN0   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN1   = 4'd1;
  localparam logic [ADDR_W-1:0] A_ST0   = 4'd2;
  localparam logic [ADDR_W-1:0] A_ST1   = 4'd3;
  localparam logic [ADDR_W-1:0] A_HI_L  = 4'd4;
  localparam logic [ADDR_W-1:0] A_HI_U  = 4'd5;
  localparam logic [ADDR_W-1:0] A_LO_L  = 4'd6;
  localparam logic [ADDR_W-1:0] A_LO_U  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;

  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NCH-1:0]    en_o,
  output logic [NCH-1:0]    clr_o,
  output logic [DW-1:0]     hi_o,
  output logic [DW-1:0]     lo_o,
  output logic              ie_o
);
  localparam int NB = NCH / REG_W;
  localparam int UW = DW - REG_W;

  logic [NCH-1:0] en_q;
  logic [DW-1:0]  hi_q, lo_q;
  logic           ie_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[b*REG_W +: REG_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_EN0 + b))
        en_q[b*REG_W +: REG_W] <= wr_data;
    end
    assign clr_o[b*REG_W +: REG_W] =
      (wr_en && wr_addr == ADDR_W'(A_ST0 + b)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '1;
      lo_q <= '0;
      ie_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_HI_L: hi_q[REG_W-1:0]  <= wr_data;
        A_HI_U: hi_q[DW-1:REG_W] <= wr_data[UW-1:0];
        A_LO_L: lo_q[REG_W-1:0]  <= wr_data;
        A_LO_U: lo_q[DW-1:REG_W] <= wr_data[UW-1:0];
        A_CTRL: ie_q             <= wr_data[CTRL_IE_BIT];
        default: ;
      endcase
    end
  end

  assign en_o = en_q;
  assign hi_o = hi_q;
  assign lo_o = lo_q;
  assign ie_o = ie_q;

  // R6
  clr_onehot_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> wr_en);
endmodule

// File: rtl/awd_compare.sv
module awd_compare #(
  parameter int NCH = 16,
  parameter int DW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [CW-1:0]  chan,
  input  logic [DW-1:0]  data,
  input  logic [NCH-1:0] en,
  input  logic [DW-1:0]  hi,
  input  logic [DW-1:0]  lo,
  output logic [NCH-1:0] hit_o
);
  logic outside;

  assign outside = (data > hi) || (data < lo);

  always_comb begin
    hit_o = '0;
    if (take && outside && en[chan]) hit_o[chan] = 1'b1;
  end

  // R4
  hit_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~en) == '0);

  // R5
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));

  // R1
  hit_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (hit_o == '0));
endmodule

// File: rtl/awd_status.sv
module awd_status #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] st_o,
  output logic           flag_o
);
  logic [NCH-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr) | hit;
  end

  assign st_o   = st_q;
  assign flag_o = |st_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5
    st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr[i]) |=> st_q[i]);
    // R7
    st_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> st_q[i]);
  end
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
  import awd_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CW-1:0]     res_chan,
  input  logic [DW-1:0]     res_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  localparam int UW = DW - REG_W;

  logic [NCH-1:0] en, clr, hit, st;
  logic [DW-1:0]  hi, lo;
  logic           ie, flag, take;

  assign res_ready = 1'b1;
  assign take      = res_valid & res_ready;

  awd_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .en_o(en), .clr_o(clr), .hi_o(hi), .lo_o(lo),
    .ie_o(ie)
  );

  awd_compare #(.NCH(NCH), .DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .take(take), .chan(res_chan),
    .data(res_data), .en(en), .hi(hi), .lo(lo), .hit_o(hit)
  );

  awd_status #(.NCH(NCH)) u_st (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .st_o(st),
    .flag_o(flag)
  );

  assign irq = flag & ie;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN0:  rd_data = en[REG_W-1:0];
      A_EN1:  rd_data = en[2*REG_W-1:REG_W];
      A_ST0:  rd_data = st[REG_W-1:0];
      A_ST1:  rd_data = st[2*REG_W-1:REG_W];
      A_HI_L: rd_data = hi[REG_W-1:0];
      A_HI_U: rd_data = {{(REG_W-UW){1'b0}}, hi[DW-1:REG_W]};
      A_LO_L: rd_data = lo[REG_W-1:0];
      A_LO_U: rd_data = {{(REG_W-UW){1'b0}}, lo[DW-1:REG_W]};
      A_CTRL: begin
        rd_data[CTRL_IE_BIT]   = ie;
        rd_data[CTRL_FLAG_BIT] = flag;
      end
      default: rd_data = '0;
    endcase
  end

  // R9
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(res_valid) || $past(wr_en)));

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready);

  // R8
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0));
endmodule

// File: tb/awd_monitor_bench.sv
module awd_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [3:0] res_chan = '0;
  logic [9:0] res_data = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  awd_monitor u_awd_monitor (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // reference model state
  logic [15:0] m_en = '0, m_st = '0;
  logic [9:0]  m_hi = 10'h3FF, m_lo = '0;
  logic        m_ie = 1'b0;

  typedef struct {
    logic [15:0] st;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, then push the expected outcome
  task automatic step(input logic v, input logic [3:0] ch,
                      input logic [9:0] d, input logic w,
                      input logic [3:0] a, input logic [7:0] wd,
                      input string tag);
    logic [15:0] hit, clr;
    exp_t e;
    @(negedge clk);
    res_valid = v; res_chan = ch; res_data = d;
    wr_en = w; wr_addr = a; wr_data = wd;
    hit = '0; clr = '0;
    if (v && m_en[ch] && (d > m_hi || d < m_lo)) hit[ch] = 1'b1;
    if (w && a == 4'd2) clr[7:0]  = wd;
    if (w && a == 4'd3) clr[15:8] = wd;
    @(posedge clk);
    m_st = (m_st & ~clr) | hit;
    if (w) begin
      case (a)
        4'd0: m_en[7:0]  = wd;
        4'd1: m_en[15:8] = wd;
        4'd4: m_hi[7:0]  = wd;
        4'd5: m_hi[9:8]  = wd[1:0];
        4'd6: m_lo[7:0]  = wd;
        4'd7: m_lo[9:8]  = wd[1:0];
        4'd8: m_ie       = wd[0];
        default: ;
      endcase
    end
    e.st = m_st; e.irq = (|m_st) & m_ie; e.tag = tag;
    exp_q.push_back(e);
    #1;
    res_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic result(input logic [3:0] ch, input logic [9:0] d,
                        input string tag);
    step(1'b1, ch, d, 1'b0, 4'd0, 8'd0, tag);
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] wd,
                      input string tag);
    step(1'b0, 4'd0, 10'd0, 1'b1, a, wd, tag);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp,
                        input string tag);
    @(negedge clk);
    #3;
    rd_addr = a;
    #1;
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  // monitor: pop expected items and compare against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [15:0] got;
        e = exp_q.pop_front();
        rd_addr = 4'd2; #1; got[7:0] = rd_data;
        rd_addr = 4'd3; #1; got[15:8] = rd_data;
        check({e.tag, " status"}, 32'(got), 32'(e.st));
        check({e.tag, " irq"}, 32'(irq), 32'(e.irq));
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state (R2, R1)
    rd_chk(4'd2, 8'h00, "R2 reset status lo");
    rd_chk(4'd3, 8'h00, "R2 reset status hi");
    rd_chk(4'd4, 8'hFF, "R2 reset hi thr low byte");
    rd_chk(4'd5, 8'h03, "R2 reset hi thr upper");
    rd_chk(4'd6, 8'h00, "R2 reset lo thr");
    rd_chk(4'd8, 8'h00, "R2 reset ctrl");
    check("R1 ready high", 32'(res_ready), 32'd1);
    check("R9 reset irq", 32'(irq), 32'd0);

    // window 200..600, enable ch0 and ch9
    wreg(4'd4, 8'h58, "R2 hi low");      // 600 = 0x258
    wreg(4'd5, 8'h02, "R2 hi up");
    wreg(4'd6, 8'hC8, "R2 lo low");      // 200 = 0x0C8
    wreg(4'd7, 8'h00, "R2 lo up");
    wreg(4'd0, 8'h01, "R4 en ch0");
    wreg(4'd1, 8'h02, "R4 en ch9");
    rd_chk(4'd4, 8'h58, "R2 hi readback low");
    rd_chk(4'd5, 8'h02, "R2 hi readback up");
    rd_chk(4'd6, 8'hC8, "R2 lo readback");
    rd_chk(4'd1, 8'h02, "R2 en hi readback");

    // boundaries (R3)
    result(4'd0, 10'd600, "R3 equal high");
    result(4'd0, 10'd200, "R3 equal low");
    result(4'd0, 10'd400, "R3 inside");
    result(4'd0, 10'd601, "R3 R5 above high");
    // disabled channel and invalid beat (R4, R1)
    result(4'd3, 10'd1000, "R4 disabled ch3");
    result(4'd8, 10'd0, "R4 disabled ch8");
    step(1'b0, 4'd9, 10'd1023, 1'b0, 4'd0, 8'd0, "R1 valid low");
    result(4'd9, 10'd199, "R3 R5 below low ch9");
    rd_chk(4'd8, 8'h02, "R8 flag with ie off");
    // interrupt enable (R9)
    wreg(4'd8, 8'h01, "R9 ie on");
    rd_chk(4'd8, 8'h03, "R8 flag and ie");
    // partial clears (R6)
    wreg(4'd2, 8'h00, "R6 write zero");
    wreg(4'd2, 8'h01, "R6 clear ch0");
    wreg(4'd3, 8'h02, "R6 R9 clear ch9");
    rd_chk(4'd8, 8'h01, "R8 flag cleared");
    // event and clear on the same bit in one cycle (R7)
    step(1'b1, 4'd0, 10'd1023, 1'b1, 4'd2, 8'h01, "R7 set wins");
    wreg(4'd8, 8'h00, "R9 ie off");
    wreg(4'd2, 8'hFF, "R6 clear all");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule